// File: doc/BRIEF.md
# Windowed Extended Register Access Bridge

This block lets a host reach a large extended register space through two small direct registers. The first is a control word. Its top two bits choose an access mode, and its low five bits name a device. The second is a shared window register. In address mode, a write to the window sets a 16-bit extended pointer. In the three data modes, an access to the window reads or writes the extended register that the pointer selects. Two of the data modes step the pointer forward after the access.

The host uses a one-cycle synchronous request port: valid, write flag, direct address and write data. Read data comes back on the next cycle, marked by a read-valid pulse. The extended registers sit outside the block. The bridge drives a write strobe, a read strobe, an address and write data. It takes read data back combinationally in the same cycle.

A typical sequence for a burst write has four steps:
1. Set the control word to address mode with device 31.
2. Write the start address to the window.
3. Set the control word to a stepping data mode.
4. Write data words to the window one after another. Each word lands one extended address higher than the one before.

Top module: `ixb_top`

## Requirements
- R1: After a synchronous reset, the control word and the pointer are zero, host_rvalid and host_rdata are zero, and neither extended strobe is asserted.
- R2: A write to direct address 0x0D stores all 16 bits in the control word. A read of 0x0D returns the last stored value on host_rdata in the next cycle, with host_rvalid high for that one cycle.
- R3: With mode bits [15:14] = 00 and device bits [4:0] = 31, a window write (direct address 0x0E) loads the pointer, and a window read returns the pointer.
- R4: With mode 01, a window write drives ext_wr_en with ext_addr equal to the pointer and ext_wdata equal to the host data. A window read returns ext_rdata at the pointer. The pointer never moves.
- R5: With mode 10, the pointer increments by one after every window read and every window write.
- R6: With mode 11, the pointer increments by one after every window write, and window reads leave it unchanged.
- R7: An increment from pointer 0xFFFF gives 0x0000.
- R8: When the device bits are not 31, a window write causes no extended strobe and leaves the pointer unchanged, and a window read returns zero.
- R9: An access to any direct address other than 0x0D and 0x0E returns zero on read and changes no state on write.
- R10: Extended strobes are asserted only in the cycle of a window access in a data mode, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_valid | input | 1 | Host request present this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Direct register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid one cycle after a read request |
| host_rvalid | output | 1 | Pulses with read data |
| ext_wr_en | output | 1 | Extended register write strobe |
| ext_rd_en | output | 1 | Extended register read strobe |
| ext_addr | output | 16 | Extended register address (the pointer) |
| ext_wdata | output | 16 | Extended register write data |
| ext_rdata | input | 16 | Extended register read data, same cycle |

## Verification
A pointer that is off by one, or that steps in the wrong mode, shows up on ext_addr at the next data access. It also shows up as wrong data returned one cycle after a read, so a burst of two accesses exposes it. A control word that is stored wrong shows up in its own read-back one cycle after the read request. A device-match fault shows up as a strobe in the same cycle as a blocked access, or as a moved pointer on the next address-mode read. The bench compares the strobes, the address and the write data in every access cycle, and the returned data in the cycle after each read.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
  localparam int REG_W = 16;
  localparam int PTR_W = 16;

  typedef enum logic [1:0] {
    FN_ADDR        = 2'b00,
    FN_DATA        = 2'b01,
    FN_DATA_INC_RW = 2'b10,
    FN_DATA_INC_W  = 2'b11
  } fn_e;

  // mode field lives in the top two bits of the control word
  function automatic fn_e fn_of(input logic [REG_W-1:0] ctrl);
    return fn_e'(ctrl[REG_W-1 -: 2]);
  endfunction

  // does this access step the pointer afterwards
  function automatic logic inc_after(input fn_e fn, input logic is_write);
    case (fn)
      FN_DATA_INC_RW: inc_after = 1'b1;
      FN_DATA_INC_W:  inc_after = is_write;
      default:        inc_after = 1'b0;
    endcase
  endfunction

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction
endpackage

// File: rtl/ixb_ctrl_reg.sv
module ixb_ctrl_reg
  import ixb_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int DEV_ID = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q,
  output fn_e              fn,
  output logic             dev_ok
);
  localparam logic [DEV_W-1:0] DEV_MATCH = DEV_W'(DEV_ID);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end

  assign fn     = fn_of(q);
  assign dev_ok = (q[DEV_W-1:0] == DEV_MATCH);

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == $past(wdata)));
endmodule

// File: rtl/ixb_ptr.sv
module ixb_ptr
  import ixb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr_next(ptr);
  end

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && ptr == '1) |=> (ptr == '0));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(ptr));
endmodule

// File: rtl/ixb_decode.sv
module ixb_decode
  import ixb_pkg::*;
#(
  parameter int                DIR_AW    = 5,
  parameter logic [DIR_AW-1:0] CTRL_ADDR = 5'h0D,
  parameter logic [DIR_AW-1:0] WIN_ADDR  = 5'h0E
) (
  input  logic              hv,
  input  logic              hw,
  input  logic [DIR_AW-1:0] haddr,
  input  logic [REG_W-1:0]  ctrl_q,
  input  fn_e               fn,
  input  logic              dev_ok,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [REG_W-1:0]  ext_rdata,
  output logic              ctrl_we,
  output logic              ptr_load,
  output logic              ptr_inc,
  output logic              ext_wr,
  output logic              ext_rd,
  output logic              rd_fire,
  output logic [REG_W-1:0]  rd_val
);
  logic hit_ctrl, hit_win;

  assign hit_ctrl = hv && (haddr == CTRL_ADDR);
  assign hit_win  = hv && (haddr == WIN_ADDR);
  assign rd_fire  = hv && !hw;
  assign ctrl_we  = hit_ctrl && hw;

  always_comb begin
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    ext_wr   = 1'b0;
    ext_rd   = 1'b0;
    rd_val   = '0;
    if (hit_ctrl && !hw) rd_val = ctrl_q;
    if (hit_win && dev_ok) begin
      if (fn == FN_ADDR) begin
        ptr_load = hw;
        if (!hw) rd_val = REG_W'(ptr);
      end else begin
        ext_wr  = hw;
        ext_rd  = !hw;
        ptr_inc = inc_after(fn, hw);
        if (!hw) rd_val = ext_rdata;
      end
    end
  end
endmodule

// File: rtl/ixb_top.sv
module ixb_top
  import ixb_pkg::*;
#(
  parameter int                DIR_AW    = 5,
  parameter logic [DIR_AW-1:0] CTRL_ADDR = 5'h0D,
  parameter logic [DIR_AW-1:0] WIN_ADDR  = 5'h0E,
  parameter int                DEV_W     = 5,
  parameter int                DEV_ID    = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [DIR_AW-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              host_rvalid,
  output logic              ext_wr_en,
  output logic              ext_rd_en,
  output logic [PTR_W-1:0]  ext_addr,
  output logic [REG_W-1:0]  ext_wdata,
  input  logic [REG_W-1:0]  ext_rdata
);
  logic [REG_W-1:0] ctrl_q;
  fn_e              fn;
  logic             dev_ok;
  logic [PTR_W-1:0] ptr;
  logic             ctrl_we, ptr_load, ptr_inc, rd_fire;
  logic [REG_W-1:0] rd_val;

  ixb_ctrl_reg #(.DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(host_wdata),
    .q(ctrl_q), .fn(fn), .dev_ok(dev_ok)
  );

  ixb_ptr u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(PTR_W'(host_wdata)),
    .inc(ptr_inc), .ptr(ptr)
  );

  ixb_decode #(.DIR_AW(DIR_AW), .CTRL_ADDR(CTRL_ADDR), .WIN_ADDR(WIN_ADDR)) u_dec (
    .hv(host_valid), .hw(host_write), .haddr(host_addr), .ctrl_q(ctrl_q),
    .fn(fn), .dev_ok(dev_ok), .ptr(ptr), .ext_rdata(ext_rdata),
    .ctrl_we(ctrl_we), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
    .ext_wr(ext_wr_en), .ext_rd(ext_rd_en), .rd_fire(rd_fire), .rd_val(rd_val)
  );

  assign ext_addr  = ptr;
  assign ext_wdata = host_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd_fire;
      if (rd_fire) host_rdata <= rd_val;
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_wr_en, ext_rd_en}));

  // R10
  strobe_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_wr_en || ext_rd_en) |-> (host_valid && host_addr == WIN_ADDR && fn != FN_ADDR));

  // R8
  devad_block_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_wr_en || ext_rd_en || ptr_load) |-> dev_ok);

  // R8
  devad_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_addr == WIN_ADDR && !dev_ok) |=> $stable(ptr));
endmodule

// File: tb/tb_ixb_top.sv
module tb_ixb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid;
  logic        ext_wr_en, ext_rd_en;
  logic [15:0] ext_addr, ext_wdata, ext_rdata;

  logic [15:0] bmem [0:255];
  int n_chk = 0, n_fail = 0;
  logic [15:0] m_ctrl = '0, m_ptr = '0;
  bit done = 0;

  always #5 clk = ~clk;

  ixb_top dut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .ext_wr_en(ext_wr_en), .ext_rd_en(ext_rd_en),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  assign ext_rdata = bmem[ext_addr[7:0]];
  always @(posedge clk) if (ext_wr_en) bmem[ext_addr[7:0]] <= ext_wdata;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic acc(input bit w, input logic [4:0] a, input logic [15:0] d, input string req);
    bit is_c, is_w, dok, ewr, erd;
    logic [1:0]  md;
    logic [15:0] exp;
    @(negedge clk);
    host_valid = 1; host_write = w; host_addr = a; host_wdata = d;
    #1;
    is_c = (a == 5'h0D); is_w = (a == 5'h0E);
    dok = (m_ctrl[4:0] == 5'd31); md = m_ctrl[15:14];
    ewr = is_w && dok && md != 2'b00 && w;
    erd = is_w && dok && md != 2'b00 && !w;
    exp = 16'h0;
    if (is_c) exp = m_ctrl;
    else if (is_w && dok) exp = (md == 2'b00) ? m_ptr : bmem[m_ptr[7:0]];
    chk(ext_wr_en == ewr, "R10 wr strobe", {15'b0, ext_wr_en}, {15'b0, ewr});
    chk(ext_rd_en == erd, "R10 rd strobe", {15'b0, ext_rd_en}, {15'b0, erd});
    if (ewr || erd) chk(ext_addr == m_ptr, req, ext_addr, m_ptr);
    if (ewr) chk(ext_wdata == d, req, ext_wdata, d);
    if (is_c && w) m_ctrl = d;
    if (is_w && dok) begin
      if (md == 2'b00) begin if (w) m_ptr = d; end
      else if (md == 2'b10 || (md == 2'b11 && w)) m_ptr = m_ptr + 16'd1;
    end
    @(posedge clk); #1;
    host_valid = 0;
    chk(host_rvalid == !w, {req, " rvalid"}, {15'b0, host_rvalid}, {15'b0, !w});
    if (!w) chk(host_rdata == exp, req, host_rdata, exp);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'h1000 + 16'(i * 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(host_rvalid == 0, "R1 rvalid", {15'b0, host_rvalid}, 16'h0);
    chk(host_rdata == 0, "R1 rdata", host_rdata, 16'h0);
    chk(!ext_wr_en && !ext_rd_en, "R1 strobes", {14'b0, ext_wr_en, ext_rd_en}, 16'h0);
    rst = 0;
    acc(0, 5'h0D, 0, "R1 ctrl zero");
    // R2 control readback
    acc(1, 5'h0D, 16'h3FFF, "R2");
    acc(0, 5'h0D, 0, "R2 readback");
    acc(1, 5'h0D, 16'h001F, "R2");
    acc(0, 5'h0D, 0, "R2 readback");
    // R1 pointer zero after reset; R3 address mode
    acc(0, 5'h0E, 0, "R1 ptr zero");
    acc(1, 5'h0E, 16'h0170, "R3 load");
    acc(0, 5'h0E, 0, "R3 read ptr");
    // R6 write-only stepping
    acc(1, 5'h0D, 16'hC01F, "R6");
    acc(1, 5'h0E, 16'h0C50, "R6 first write");
    acc(1, 5'h0E, 16'h0011, "R6 second write");
    acc(0, 5'h0E, 0, "R6 read no step");
    acc(0, 5'h0E, 0, "R6 read no step");
    acc(1, 5'h0D, 16'h001F, "R6");
    acc(0, 5'h0E, 0, "R6 ptr value");
    // R5 read and write stepping
    acc(1, 5'h0E, 16'h0170, "R3 load");
    acc(1, 5'h0D, 16'h801F, "R5");
    acc(0, 5'h0E, 0, "R5 read 0170");
    acc(0, 5'h0E, 0, "R5 read 0171");
    acc(1, 5'h0E, 16'hAAAA, "R5 write 0172");
    acc(0, 5'h0E, 0, "R5 read 0173");
    // R4 fixed pointer
    acc(1, 5'h0D, 16'h401F, "R4");
    acc(1, 5'h0E, 16'h5555, "R4 write");
    acc(0, 5'h0E, 0, "R4 read");
    acc(1, 5'h0E, 16'h6666, "R4 rewrite");
    acc(0, 5'h0E, 0, "R4 read again");
    acc(1, 5'h0D, 16'h001F, "R4");
    acc(0, 5'h0E, 0, "R4 ptr fixed");
    // R7 wrap in both stepping modes
    acc(1, 5'h0E, 16'hFFFF, "R7 load");
    acc(1, 5'h0D, 16'h801F, "R7");
    acc(0, 5'h0E, 0, "R7 read ffff");
    acc(0, 5'h0E, 0, "R7 read 0000");
    acc(1, 5'h0D, 16'h001F, "R7");
    acc(1, 5'h0E, 16'hFFFF, "R7 load");
    acc(1, 5'h0D, 16'hC01F, "R7");
    acc(1, 5'h0E, 16'h1234, "R7 write ffff");
    acc(1, 5'h0E, 16'h4321, "R7 write 0000");
    acc(1, 5'h0D, 16'h001F, "R7");
    acc(0, 5'h0E, 0, "R7 ptr 0001");
    // R8 device mismatch
    acc(1, 5'h0E, 16'h0040, "R8 load");
    acc(1, 5'h0D, 16'h801E, "R8");
    acc(1, 5'h0E, 16'hDEAD, "R8 write blocked");
    acc(0, 5'h0E, 0, "R8 read zero");
    acc(1, 5'h0D, 16'h001E, "R8");
    acc(1, 5'h0E, 16'h0099, "R8 load blocked");
    acc(0, 5'h0E, 0, "R8 read zero");
    acc(1, 5'h0D, 16'h401F, "R8");
    acc(0, 5'h0E, 0, "R8 data untouched");
    acc(1, 5'h0D, 16'h001F, "R8");
    acc(0, 5'h0E, 0, "R8 ptr unchanged");
    // R9 other direct addresses
    acc(1, 5'h05, 16'hBEEF, "R9 write");
    acc(0, 5'h05, 0, "R9 read zero");
    acc(1, 5'h0F, 16'h0000, "R9 write");
    acc(0, 5'h0D, 0, "R9 ctrl unchanged");
    acc(0, 5'h0E, 0, "R9 ptr unchanged");
    done = 1;
    summary();
  end
endmodule